// File: doc/BRIEF.md
# In-Order Retirement Queue

This block keeps a circular record of dispatched instructions in program order. Each record stores the architectural destination index, the tag of the rename register that will hold the result, and two status bits: one that says the instruction has finished and one that says it faulted. At dispatch the block hands back a slot number. Execution units later use that slot number to report a finish, and they also report whether the instruction faulted.

Every cycle the oldest records are examined. Finished, fault-free records at the head leave the queue in order, up to two per cycle. For each one the block presents its destination index and rename tag, so that the architectural file outside can copy the rename value across. A fault only takes effect once the faulting record is the oldest. In that cycle nothing retires and no new dispatch is accepted. On the next edge every record is dropped, the tail is pulled back to the head, and a one-cycle redirect carries the trap vector address to the fetch side.

While any queued record carries a fault, a hold output tells the execution units to stop. DEPTH must be a power of two.

Top module: `retire_queue`

## Requirements
- R1: After reset the queue is empty, `disp_ready_o` is 1, `disp_slot_o` is 0, and no retire lane, redirect or hold is active.
- R2: A dispatch is accepted when `disp_valid_i` and `disp_ready_o` are both 1. It is stored at the slot shown on `disp_slot_o`, and that slot number then advances by one, modulo DEPTH. When the queue is full, `disp_ready_o` is 0 and dispatch has no effect.
- R3: A finish report (`fin_valid_i` with `fin_slot_i`) marks the addressed record finished and latches `fin_fault_i` into it. A report to a slot that holds no record, or to one that is already finished, is ignored.
- R4: Lane 0 (bit 0 of `ret_valid_o`, bits [AREG_W-1:0] of `ret_areg_o`, bits [RTAG_W-1:0] of `ret_rtag_o`) is active in the cycle after the head record's finish is reported, provided it is fault-free. It shows that record's destination index and rename tag. An unfinished head holds back every younger record.
- R5: Lane 1 (bit 1, with the next field up) shows the record after the head. It is active only when lane 0 is also active and that record is finished and fault-free. Every record shown on a lane is removed at the following edge.
- R6: A fault on a record that is not the head causes no redirect. Older records keep retiring, and the faulting record never appears on a retire lane.
- R7: In a cycle where the head is finished and faulted, no lane is active and `disp_ready_o` is 0. At the next edge all records are discarded and the queue is empty, with `disp_slot_o` equal to the faulting record's slot.
- R8: `redirect_o` is 1 for exactly the one cycle after a flush, with `redirect_addr_o` equal to TRAP_VEC. At all other times `redirect_addr_o` is 0.
- R9: `unit_hold_o` is 1 while any queued record carries a fault. It goes to 0 in the cycle in which `redirect_o` pulses.
- R10: `full_o` is 1 exactly when DEPTH records are held, and `empty_o` is 1 exactly when none are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid_i | input | 1 | Dispatch request |
| disp_areg_i | input | AREG_W | Architectural destination index |
| disp_rtag_i | input | RTAG_W | Rename register tag |
| disp_ready_o | output | 1 | Dispatch will be accepted |
| disp_slot_o | output | log2(DEPTH) | Slot given to the next dispatch |
| fin_valid_i | input | 1 | Finish report |
| fin_slot_i | input | log2(DEPTH) | Slot being reported |
| fin_fault_i | input | 1 | Reported instruction faulted |
| ret_valid_o | output | RET_W | Per-lane retire strobe |
| ret_areg_o | output | RET_W*AREG_W | Per-lane destination index |
| ret_rtag_o | output | RET_W*RTAG_W | Per-lane rename tag |
| redirect_o | output | 1 | Fetch redirect pulse |
| redirect_addr_o | output | ADDR_W | Redirect target |
| unit_hold_o | output | 1 | Execution units must stall |
| full_o | output | 1 | Queue full |
| empty_o | output | 1 | Queue empty |

## Verification
The properties assume only that reset is held for at least one edge. Since every rule they check is driven from registered state, they hold for any input pattern. The bench keeps to one finish report per cycle, but otherwise draws the finish slot uniformly. Many of those reports therefore land on empty or already-finished slots, and many dispatch attempts hit a full queue or a pending flush. This exercises the cases that must be ignored.

// File: rtl/retq_pkg.sv
package retq_pkg;

    // Status bits kept per queue slot
    typedef struct packed {
        logic busy;   // slot holds a dispatched record
        logic done;   // execution finished
        logic fault;  // execution reported a fault
    } retq_flags_t;

endpackage

// File: rtl/retq_retire_pick.sv
module retq_retire_pick
    import retq_pkg::*;
#(
    parameter  int DEPTH  = 8,
    parameter  int RET_W  = 2,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int LCNT_W = $clog2(RET_W + 1)
) (
    input  retq_flags_t [DEPTH-1:0] flg_i,
    input  logic [IDX_W-1:0]        head_i,
    output logic [RET_W-1:0]        go_o,
    output logic [LCNT_W-1:0]       cnt_o,
    output logic                    trap_o
);

    logic [RET_W-1:0] ok;

    // One candidate per lane, taken from consecutive slots starting at the head
    for (genvar k = 0; k < RET_W; k++) begin : g_lane
        logic [IDX_W-1:0] idx;
        assign idx   = head_i + IDX_W'(k);
        assign ok[k] = flg_i[idx].busy & flg_i[idx].done & ~flg_i[idx].fault;
    end

    // A lane may only go if every older lane goes as well
    always_comb begin
        logic run;
        run   = 1'b1;
        cnt_o = '0;
        for (int k = 0; k < RET_W; k++) begin
            run      = run & ok[k];
            go_o[k]  = run;
            cnt_o    = cnt_o + LCNT_W'(run);
        end
    end

    assign trap_o = flg_i[head_i].busy & flg_i[head_i].done & flg_i[head_i].fault;

endmodule

// File: rtl/retq_fault_scan.sv
module retq_fault_scan
    import retq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  retq_flags_t [DEPTH-1:0] flg_i,
    output logic                    hold_o
);

    logic [DEPTH-1:0] hit;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign hit[i] = flg_i[i].busy & flg_i[i].fault;
    end

    assign hold_o = |hit;

endmodule

// File: rtl/retire_queue.sv
module retire_queue
    import retq_pkg::*;
#(
    parameter  int               DEPTH    = 8,
    parameter  int               RET_W    = 2,
    parameter  int               AREG_W   = 5,
    parameter  int               RTAG_W   = 6,
    parameter  int               ADDR_W   = 32,
    parameter  logic [ADDR_W-1:0] TRAP_VEC = 'h700,
    localparam int               IDX_W    = $clog2(DEPTH),
    localparam int               CNT_W    = $clog2(DEPTH + 1),
    localparam int               LCNT_W   = $clog2(RET_W + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      disp_valid_i,
    input  logic [AREG_W-1:0]         disp_areg_i,
    input  logic [RTAG_W-1:0]         disp_rtag_i,
    output logic                      disp_ready_o,
    output logic [IDX_W-1:0]          disp_slot_o,
    input  logic                      fin_valid_i,
    input  logic [IDX_W-1:0]          fin_slot_i,
    input  logic                      fin_fault_i,
    output logic [RET_W-1:0]          ret_valid_o,
    output logic [RET_W*AREG_W-1:0]   ret_areg_o,
    output logic [RET_W*RTAG_W-1:0]   ret_rtag_o,
    output logic                      redirect_o,
    output logic [ADDR_W-1:0]         redirect_addr_o,
    output logic                      unit_hold_o,
    output logic                      full_o,
    output logic                      empty_o
);

    typedef struct packed {
        logic [DEPTH-1:0][AREG_W-1:0] areg;
        logic [DEPTH-1:0][RTAG_W-1:0] rtag;
        retq_flags_t [DEPTH-1:0]      flg;
        logic [IDX_W-1:0]             head;
        logic [IDX_W-1:0]             tail;
        logic [CNT_W-1:0]             count;
        logic                         redirect;
    } state_t;

    state_t q, d;

    logic [RET_W-1:0]  go;
    logic [LCNT_W-1:0] go_cnt;
    logic              trap;
    logic              accept;

    retq_retire_pick #(
        .DEPTH (DEPTH),
        .RET_W (RET_W)
    ) pick_i (
        .flg_i  (q.flg),
        .head_i (q.head),
        .go_o   (go),
        .cnt_o  (go_cnt),
        .trap_o (trap)
    );

    retq_fault_scan #(
        .DEPTH (DEPTH)
    ) scan_i (
        .flg_i  (q.flg),
        .hold_o (unit_hold_o)
    );

    assign full_o       = (q.count == CNT_W'(DEPTH));
    assign empty_o      = (q.count == '0);
    assign disp_ready_o = ~full_o & ~trap;
    assign disp_slot_o  = q.tail;
    assign accept       = disp_valid_i & disp_ready_o;

    // Next-state computation
    always_comb begin
        d          = q;
        d.redirect = 1'b0;
        if (trap) begin
            // Oldest record faulted: drop everything and point fetch at the vector
            for (int i = 0; i < DEPTH; i++) begin
                d.flg[i] = '0;
            end
            d.tail     = q.head;
            d.count    = '0;
            d.redirect = 1'b1;
        end else begin
            for (int k = 0; k < RET_W; k++) begin
                if (go[k]) begin
                    d.flg[q.head + IDX_W'(k)] = '0;
                end
            end
            d.head = q.head + IDX_W'(go_cnt);

            if (fin_valid_i && q.flg[fin_slot_i].busy && !q.flg[fin_slot_i].done) begin
                d.flg[fin_slot_i].done  = 1'b1;
                d.flg[fin_slot_i].fault = fin_fault_i;
            end

            if (accept) begin
                d.flg[q.tail].busy  = 1'b1;
                d.flg[q.tail].done  = 1'b0;
                d.flg[q.tail].fault = 1'b0;
                d.areg[q.tail]      = disp_areg_i;
                d.rtag[q.tail]      = disp_rtag_i;
                d.tail              = q.tail + IDX_W'(1);
            end

            d.count = q.count - CNT_W'(go_cnt) + CNT_W'(accept);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // Retire lane outputs
    for (genvar k = 0; k < RET_W; k++) begin : g_out
        assign ret_areg_o[k*AREG_W +: AREG_W] = q.areg[q.head + IDX_W'(k)];
        assign ret_rtag_o[k*RTAG_W +: RTAG_W] = q.rtag[q.head + IDX_W'(k)];
    end
    assign ret_valid_o = go;

    assign redirect_o      = q.redirect;
    assign redirect_addr_o = q.redirect ? TRAP_VEC : '0;

endmodule

// File: rtl/retire_queue_chk.sv
module retire_queue_chk #(
    parameter int                RET_W    = 2,
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] TRAP_VEC = 'h700
) (
    input logic              clk,
    input logic              rst_n,
    input logic              disp_ready_o,
    input logic              full_o,
    input logic              empty_o,
    input logic [RET_W-1:0]  ret_valid_o,
    input logic              redirect_o,
    input logic [ADDR_W-1:0] redirect_addr_o,
    input logic              unit_hold_o
);

    assert_full_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !disp_ready_o);

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));

    for (genvar k = 1; k < RET_W; k++) begin : g_order
        assert_lane_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ret_valid_o[k] |-> ret_valid_o[k-1]);
    end

    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (empty_o && ret_valid_o == '0));

    assert_redirect_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> !redirect_o);

    assert_redirect_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> redirect_addr_o == TRAP_VEC);

    assert_redirect_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_o |-> redirect_addr_o == '0);

    assert_hold_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> !unit_hold_o);

endmodule

bind retire_queue retire_queue_chk #(
    .RET_W    (RET_W),
    .ADDR_W   (ADDR_W),
    .TRAP_VEC (TRAP_VEC)
) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .disp_ready_o    (disp_ready_o),
    .full_o          (full_o),
    .empty_o         (empty_o),
    .ret_valid_o     (ret_valid_o),
    .redirect_o      (redirect_o),
    .redirect_addr_o (redirect_addr_o),
    .unit_hold_o     (unit_hold_o)
);

// File: tb/retire_queue_tb_top.sv
`timescale 1ns/1ps
module retire_queue_tb_top;

    localparam int          DEPTH = 8;
    localparam logic [31:0] VEC   = 32'h700;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid_i = 1'b0;
    logic [4:0]  disp_areg_i = '0;
    logic [5:0]  disp_rtag_i = '0;
    logic        disp_ready_o;
    logic [2:0]  disp_slot_o;
    logic        fin_valid_i = 1'b0;
    logic [2:0]  fin_slot_i = '0;
    logic        fin_fault_i = 1'b0;
    logic [1:0]  ret_valid_o;
    logic [9:0]  ret_areg_o;
    logic [11:0] ret_rtag_o;
    logic        redirect_o;
    logic [31:0] redirect_addr_o;
    logic        unit_hold_o;
    logic        full_o;
    logic        empty_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    retire_queue dut_i (
        .clk(clk), .rst_n(rst_n),
        .disp_valid_i(disp_valid_i), .disp_areg_i(disp_areg_i), .disp_rtag_i(disp_rtag_i),
        .disp_ready_o(disp_ready_o), .disp_slot_o(disp_slot_o),
        .fin_valid_i(fin_valid_i), .fin_slot_i(fin_slot_i), .fin_fault_i(fin_fault_i),
        .ret_valid_o(ret_valid_o), .ret_areg_o(ret_areg_o), .ret_rtag_o(ret_rtag_o),
        .redirect_o(redirect_o), .redirect_addr_o(redirect_addr_o),
        .unit_hold_o(unit_hold_o), .full_o(full_o), .empty_o(empty_o)
    );

    // Reference queue built from the requirements
    logic       m_busy [DEPTH];
    logic       m_done [DEPTH];
    logic       m_fault[DEPTH];
    logic [4:0] m_areg [DEPTH];
    logic [5:0] m_rtag [DEPTH];
    int         m_head, m_tail, m_cnt;
    logic       m_redir;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic m_ok(input int s);
        return m_busy[s] && m_done[s] && !m_fault[s];
    endfunction

    function automatic logic m_trap();
        return m_busy[m_head] && m_done[m_head] && m_fault[m_head];
    endfunction

    function automatic logic m_hold();
        logic h = 1'b0;
        for (int i = 0; i < DEPTH; i++) h |= m_busy[i] & m_fault[i];
        return h;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) begin
            m_busy[i] = 0; m_done[i] = 0; m_fault[i] = 0; m_areg[i] = 0; m_rtag[i] = 0;
        end
        m_head = 0; m_tail = 0; m_cnt = 0; m_redir = 0;
    endtask

    // Called at a falling edge: compare, advance the model, drive, wait one cycle
    task automatic step(input logic dv, input logic [4:0] ar, input logic [5:0] rt,
                        input logic fv, input logic [2:0] fs, input logic ff);
        logic l0, l1, rdy;
        int   h1;
        h1  = (m_head + 1) % DEPTH;
        l0  = m_ok(m_head);
        l1  = l0 && m_ok(h1);
        rdy = (m_cnt < DEPTH) && !m_trap();
        check("R2 disp_ready", disp_ready_o, rdy);
        check("R2 disp_slot", disp_slot_o, m_tail);
        check("R10 full", full_o, m_cnt == DEPTH);
        check("R10 empty", empty_o, m_cnt == 0);
        check("R5 ret_valid", ret_valid_o, {l1, l0});
        if (l0) begin
            check("R4 lane0 areg", ret_areg_o[4:0], m_areg[m_head]);
            check("R4 lane0 rtag", ret_rtag_o[5:0], m_rtag[m_head]);
        end
        if (l1) begin
            check("R5 lane1 areg", ret_areg_o[9:5], m_areg[h1]);
            check("R5 lane1 rtag", ret_rtag_o[11:6], m_rtag[h1]);
        end
        check("R8 redirect", redirect_o, m_redir);
        check("R8 redirect_addr", redirect_addr_o, m_redir ? VEC : 32'h0);
        check("R9 hold", unit_hold_o, m_hold());

        m_redir = 0;
        if (m_trap()) begin
            for (int i = 0; i < DEPTH; i++) begin
                m_busy[i] = 0; m_done[i] = 0; m_fault[i] = 0;
            end
            m_tail = m_head; m_cnt = 0; m_redir = 1;
        end else begin
            if (l0) begin m_busy[m_head] = 0; m_done[m_head] = 0; m_cnt--; end
            if (l1) begin m_busy[h1] = 0; m_done[h1] = 0; m_cnt--; end
            m_head = (m_head + (l0 ? 1 : 0) + (l1 ? 1 : 0)) % DEPTH;
            if (fv && m_busy[fs] && !m_done[fs]) begin
                m_done[fs] = 1; m_fault[fs] = ff;
            end
            if (dv && rdy) begin
                m_busy[m_tail] = 1; m_done[m_tail] = 0; m_fault[m_tail] = 0;
                m_areg[m_tail] = ar; m_rtag[m_tail] = rt;
                m_tail = (m_tail + 1) % DEPTH; m_cnt++;
            end
        end

        disp_valid_i = dv; disp_areg_i = ar; disp_rtag_i = rt;
        fin_valid_i = fv; fin_slot_i = fs; fin_fault_i = ff;
        @(negedge clk);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 empty", empty_o, 1);
        check("R1 ready", disp_ready_o, 1);
        check("R1 slot", disp_slot_o, 0);
        check("R1 lanes", ret_valid_o, 0);
        check("R1 redirect", redirect_o, 0);
        check("R1 hold", unit_hold_o, 0);

        // R3: finish to an empty slot is ignored
        step(0, 0, 0, 1, 3, 0);
        step(1, 5'd1, 6'd11, 0, 0, 0);
        step(1, 5'd2, 6'd12, 0, 0, 0);
        step(1, 5'd3, 6'd13, 0, 0, 0);
        check("R3 stray finish ignored", ret_valid_o, 0);
        step(0, 0, 0, 1, 1, 0);
        check("R4 head waits", ret_valid_o, 0);
        step(0, 0, 0, 1, 0, 0);
        check("R5 two lanes", ret_valid_o, 2'b11);
        check("R4 lane0 dest", ret_areg_o[4:0], 5'd1);
        check("R5 lane1 dest", ret_areg_o[9:5], 5'd2);
        idle();

        // R6/R7: younger fault held until it is oldest
        step(1, 5'd4, 6'd14, 0, 0, 0);
        step(1, 5'd5, 6'd15, 0, 0, 0);
        step(0, 0, 0, 1, 4, 1);
        check("R6 no early redirect", redirect_o, 0);
        check("R9 hold raised", unit_hold_o, 1);
        step(0, 0, 0, 1, 2, 0);
        check("R4 lane0 only", ret_valid_o, 2'b01);
        step(0, 0, 0, 1, 3, 0);
        check("R6 faulty not paired", ret_valid_o, 2'b01);
        idle();
        check("R7 ready low at trap", disp_ready_o, 0);
        check("R7 no retire at trap", ret_valid_o, 0);
        step(1, 5'd9, 6'd9, 0, 0, 0);
        check("R7 flushed", empty_o, 1);
        check("R7 tail at head", disp_slot_o, 4);
        check("R8 pulse", redirect_o, 1);
        check("R8 vector", redirect_addr_o, VEC);
        check("R9 hold released", unit_hold_o, 0);
        idle();
        check("R8 single cycle", redirect_o, 0);

        // R2/R10: fill, overfill, drain
        for (int i = 0; i < 9; i++) step(1, 5'(i), 6'(i + 20), 0, 0, 0);
        check("R10 full", full_o, 1);
        check("R2 full ignores dispatch", disp_slot_o, 4);
        for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 3'((4 + i) % 8), 0);
        repeat (6) idle();

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 10) < 6, 5'($urandom), 6'($urandom),
                 ($urandom % 10) < 7, 3'($urandom), ($urandom % 16) == 0);
        end

        summary();
        $finish;
    end

endmodule